// File: doc/BRIEF.md
# Key-Guarded Buffer Mode Register

This block is an 8-bit memory-mapped configuration register that software cannot change by accident. A value only reaches the live register when the bus delivers three writes in a fixed order: an unlock code to a first key address, the new value to the register address, and a confirm code to a second key address. The new value waits in a pending holding register until the confirm code arrives. Any stray write in between throws the pending value away.

The low four bits of the live register drive four mode-enable outputs. Each output puts one output buffer into amplifier mode. The upper four bits are reserved. They always read back as zero. The bus is a plain address / write-strobe / write-data / read-strobe / read-data interface. Read data is combinational on the read strobe.

Top module: `guarded_cfg_reg`

## Requirements
- R1: After reset the live register holds 0x00, all four mode-enable outputs are 0, and a read of the register address returns 0x00.
- R2: A read at the register address (0xFFFF0654) returns the live value, with bits [7:4] always 0 whatever value was written.
- R3: The three writes 0x9A to the first key address (0xFFFF0650), then value V to the register address, then 0x0C to the second key address (0xFFFF0658) set the live register to V & 0x0F. Output bit i is 1 (amplifier mode) exactly when live bit i is 1, and 0 (normal mode) otherwise.
- R4: Neither the outputs nor register reads show the pending value. The outputs change only on the clock edge that samples the accepted confirm write, so they are unchanged while that write is on the bus and hold the new value in the following cycle.
- R5: When no sequence is open, a first-key write with any code other than 0x9A, a register write, or a write to any other address leaves the live value unchanged and opens no sequence.
- R6: After an accepted unlock code, a write to any address other than the register address closes the sequence, including a second unlock write. A later confirm write then has no effect.
- R7: Once a value is pending, any write other than 0x0C to the second key address discards that value and closes the sequence, and the live value stays unchanged.
- R8: Reads at either key address return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 32 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, zero when no decoded read |
| opamp_en | output | 4 | Per-buffer amplifier-mode enables from the live register |

## Verification
The bench builds the block with its default parameters: four channels, a 32-bit address map, unlock code 0x9A and confirm code 0x0C. It uses the three addresses from the requirements. The directed cases hit each abort path of the sequencer and the exact cycle in which the outputs change. The random phase draws most of its writes to the three decoded addresses, with the correct codes favoured. This makes complete, broken and restarted sequences all frequent, and it writes values with the reserved bits set so that the masking is exercised.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_HELD  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/gcr_rst_sync.sv
module gcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gcr_addr_decode.sv
module gcr_addr_decode #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] KEY1_ADDR = 32'hFFFF_0650,
  parameter logic [31:0] CFG_ADDR  = 32'hFFFF_0654,
  parameter logic [31:0] KEY2_ADDR = 32'hFFFF_0658
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_key1,
  output logic              hit_cfg,
  output logic              hit_key2
);
  localparam logic [ADDR_W-1:0] K1 = KEY1_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] CF = CFG_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] K2 = KEY2_ADDR[ADDR_W-1:0];

  always_comb begin
    hit_key1 = (addr == K1);
    hit_cfg  = (addr == CF);
    hit_key2 = (addr == K2);
  end
endmodule

// File: rtl/gcr_key_fsm.sv
module gcr_key_fsm
  import gcr_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  UNLOCK    = 8'h9A,
  parameter logic [7:0]  CONFIRM   = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit_key1,
  input  logic              hit_cfg,
  input  logic              hit_key2,
  output logic              commit,
  output logic [DATA_W-1:0] pend_val
);
  localparam logic [DATA_W-1:0] UNLOCK_W  = DATA_W'(UNLOCK);
  localparam logic [DATA_W-1:0] CONFIRM_W = DATA_W'(CONFIRM);

  seq_state_t        st_q, st_d;
  logic [DATA_W-1:0] pend_q, pend_d;
  logic              pend_en;
  logic              unlock_ok, confirm_ok;

  always_comb begin
    unlock_ok  = hit_key1 && (wdata == UNLOCK_W);
    confirm_ok = hit_key2 && (wdata == CONFIRM_W);
  end

  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    pend_en = 1'b0;
    commit  = 1'b0;
    if (wr) begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (unlock_ok) st_d = SEQ_ARMED;
        end
        SEQ_ARMED: begin
          if (hit_cfg) begin
            st_d    = SEQ_HELD;
            pend_d  = wdata;
            pend_en = 1'b1;
          end else begin
            st_d = SEQ_IDLE;
          end
        end
        SEQ_HELD: begin
          st_d    = SEQ_IDLE;
          commit  = confirm_ok;
          pend_d  = '0;
          pend_en = 1'b1;
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      pend_q <= '0;
    end else begin
      st_q <= st_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign pend_val = pend_q;

  // R5
  idle_wrong_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_IDLE && wr && !(hit_key1 && wdata == UNLOCK_W)) |=> (st_q == SEQ_IDLE));

  // R6
  armed_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_ARMED && wr && !hit_cfg) |=> (st_q == SEQ_IDLE));

  // R7
  held_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_HELD && wr) |=> (st_q == SEQ_IDLE && pend_q == '0));

  // R3
  held_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_HELD && $past(st_q) != SEQ_HELD) |-> ($past(st_q) == SEQ_ARMED && $past(wr) && $past(hit_cfg)));
endmodule

// File: rtl/gcr_live_reg.sv
module gcr_live_reg #(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [DATA_W-1:0] pend_val,
  input  logic              rd,
  input  logic              hit_key1,
  input  logic              hit_cfg,
  input  logic              hit_key2,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] mode_en
);
  localparam logic [DATA_W-1:0] LIVE_MASK = DATA_W'((1 << NUM_CH) - 1);

  logic [NUM_CH-1:0] live_q, live_d;

  always_comb begin
    live_d = pend_val[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      live_q <= '0;
    else if (commit) live_q <= live_d;
  end

  always_comb begin
    rdata = '0;
    if (rd && hit_cfg) rdata = DATA_W'(live_q) & LIVE_MASK;
  end

  assign mode_en = live_q;

  // R4
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(mode_en));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:NUM_CH] == '0);

  // R8
  key_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (hit_key1 || hit_key2)) |-> (rdata == '0));
endmodule

// File: rtl/guarded_cfg_reg.sv
module guarded_cfg_reg #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 8,
  parameter int          NUM_CH    = 4,
  parameter logic [31:0] KEY1_ADDR = 32'hFFFF_0650,
  parameter logic [31:0] CFG_ADDR  = 32'hFFFF_0654,
  parameter logic [31:0] KEY2_ADDR = 32'hFFFF_0658,
  parameter logic [7:0]  UNLOCK    = 8'h9A,
  parameter logic [7:0]  CONFIRM   = 8'h0C
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] opamp_en
);
  logic              rst_n;
  logic              hit_key1, hit_cfg, hit_key2;
  logic              commit;
  logic [DATA_W-1:0] pend_val;

  gcr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_sync(rst_n)
  );

  gcr_addr_decode #(
    .ADDR_W(ADDR_W), .KEY1_ADDR(KEY1_ADDR), .CFG_ADDR(CFG_ADDR), .KEY2_ADDR(KEY2_ADDR)
  ) u_dec (
    .addr(bus_addr), .hit_key1(hit_key1), .hit_cfg(hit_cfg), .hit_key2(hit_key2)
  );

  gcr_key_fsm #(
    .DATA_W(DATA_W), .UNLOCK(UNLOCK), .CONFIRM(CONFIRM)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata),
    .hit_key1(hit_key1), .hit_cfg(hit_cfg), .hit_key2(hit_key2),
    .commit(commit), .pend_val(pend_val)
  );

  gcr_live_reg #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_live (
    .clk(clk), .rst_n(rst_n), .commit(commit), .pend_val(pend_val),
    .rd(bus_rd), .hit_key1(hit_key1), .hit_cfg(hit_cfg), .hit_key2(hit_key2),
    .rdata(bus_rdata), .mode_en(opamp_en)
  );

  // R3
  out_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opamp_en != $past(opamp_en)) |-> ($past(bus_wr) && $past(hit_key2) && $past(bus_wdata) == DATA_W'(CONFIRM)));
endmodule

// File: tb/guarded_cfg_reg_test.sv
module guarded_cfg_reg_test;
  localparam logic [31:0] A_K1  = 32'hFFFF_0650;
  localparam logic [31:0] A_CFG = 32'hFFFF_0654;
  localparam logic [31:0] A_K2  = 32'hFFFF_0658;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [3:0]  opamp_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int         m_st = 0;
  logic [7:0] m_pend = '0;
  logic [7:0] m_live = '0;

  always #5 clk = ~clk;

  guarded_cfg_reg uut (
    .clk(clk), .arst_n(arst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .opamp_en(opamp_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic void model_wr(input logic [31:0] a, input logic [7:0] d);
    case (m_st)
      0: if (a == A_K1 && d == 8'h9A) m_st = 1;
      1: if (a == A_CFG) begin m_pend = d; m_st = 2; end else m_st = 0;
      default: begin
        if (a == A_K2 && d == 8'h0C) m_live = m_pend & 8'h0F;
        m_st = 0;
      end
    endcase
  endfunction

  task automatic bus_write(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic check_state(input string tag);
    logic [7:0] v;
    chk(tag, {4'h0, opamp_en}, m_live);
    bus_read(A_CFG, v);
    chk(tag, v, m_live);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {4'h0, opamp_en}, 8'h00);
    bus_read(A_CFG, v);
    chk("R1 read", v, 8'h00);

    // R3 + R2 full sequence with reserved bits set
    bus_write(A_K1, 8'h9A);
    bus_write(A_CFG, 8'hF5);
    // R4 pending value not visible
    check_state("R4 pending hidden");
    chk("R4 still old", {4'h0, opamp_en}, 8'h00);
    // the read above was not a write: sequence still held
    @(negedge clk);
    bus_addr = A_K2; bus_wdata = 8'h0C; bus_wr = 1'b1;
    #1 chk("R4 before edge", {4'h0, opamp_en}, 8'h00);
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(A_K2, 8'h0C);
    chk("R4 after edge", {4'h0, opamp_en}, 8'h05);
    check_state("R3 commit");
    chk("R2 masked", m_live, 8'h05);

    // R8 key reads
    bus_read(A_K1, v);
    chk("R8 key1 read", v, 8'h00);
    bus_read(A_K2, v);
    chk("R8 key2 read", v, 8'h00);

    // R5 wrong unlock, bare cfg write
    bus_write(A_K1, 8'h9B);
    bus_write(A_CFG, 8'h0A);
    bus_write(A_K2, 8'h0C);
    check_state("R5 wrong unlock");
    bus_write(A_CFG, 8'h0F);
    bus_write(A_K2, 8'h0C);
    check_state("R5 bare cfg");

    // R6 armed then other address
    bus_write(A_K1, 8'h9A);
    bus_write(A_K1, 8'h9A);
    bus_write(A_CFG, 8'h0A);
    bus_write(A_K2, 8'h0C);
    check_state("R6 double unlock");
    bus_write(A_K1, 8'h9A);
    bus_write(32'h0000_1234, 8'h00);
    bus_write(A_CFG, 8'h0A);
    bus_write(A_K2, 8'h0C);
    check_state("R6 stray address");

    // R7 held then wrong confirm / other address
    bus_write(A_K1, 8'h9A);
    bus_write(A_CFG, 8'h0A);
    bus_write(A_K2, 8'h0D);
    bus_write(A_K2, 8'h0C);
    check_state("R7 wrong confirm");
    bus_write(A_K1, 8'h9A);
    bus_write(A_CFG, 8'h0A);
    bus_write(A_CFG, 8'h0B);
    bus_write(A_K2, 8'h0C);
    check_state("R7 second cfg write");

    // R3 sequence after aborts still works
    bus_write(A_K1, 8'h9A);
    bus_write(A_CFG, 8'h0A);
    bus_write(A_K2, 8'h0C);
    check_state("R3 recovery");

    // random phase covering R3 R5 R6 R7
    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [31:0] a;
      logic [7:0]  d;
      sel = $urandom_range(0, 9);
      d   = 8'($urandom);
      if (sel < 3) begin
        a = A_K1;
        if ($urandom_range(0, 3) != 0) d = 8'h9A;
      end else if (sel < 6) begin
        a = A_CFG;
      end else if (sel < 9) begin
        a = A_K2;
        if ($urandom_range(0, 3) != 0) d = 8'h0C;
      end else begin
        a = $urandom;
      end
      bus_write(a, d);
      if ((i % 4) == 3) check_state("R3/R5/R6/R7 random");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule